// File: doc/BRIEF.md
# Macroblock Decoder Command Front-End

This block sits at the entry of a macroblock decoder. Software or a DMA engine writes 32-bit words to one of two offsets. A write to the data offset is either a new command or a parameter word of the command in progress. A small receive state machine decides which. A write to the control offset updates a status register, which can be read back at the same offset.

Two commands take parameters. One loads the quantisation tables: 16 words for luma only, or 32 words for luma and chroma. The other loads the scale table, always 32 words. Each parameter word is passed on to the downstream table memory with its word index and the kind of table it belongs to. When the last word has arrived, the block goes back to waiting for a command. The decode-macroblock command is accepted but has no effect here. Inverse quantisation, the inverse transform, colour conversion and the output path are not part of this block.

A control write with its top bit set resets both the status register and the receive logic. Every control write also copies two of its bits into the status register at a shifted position.

Top module: `mbd_cmd_front`

## Requirements
- R1: After rst_n is released, rx_state is 0 (waiting for command) and the status register reads 0x80040000.
- R2: A data write in state 0 whose bits 31:29 equal 2 starts a quant-table load. With bit 0 set, rx_state becomes 3 and 32 parameter words follow. With bit 0 clear, rx_state becomes 2 and 16 words follow.
- R3: A data write in state 0 whose bits 31:29 equal 3 moves rx_state to 4 (scale table), and 32 parameter words follow.
- R4: A data write in state 0 whose bits 31:29 are 0, 1 or 4 to 7 leaves rx_state at 0 and raises no table write. rx_state never takes the value 1 (block data).
- R5: Each data write in states 2, 3 or 4 raises tbl_we in the same cycle, with tbl_data equal to the written word. tbl_idx is 0 for the first word after the command and rises by one per word. tbl_kind is 0 for quant tables and 1 for the scale table.
- R6: The clock edge that accepts the final expected parameter word returns rx_state to 0. The next data word is decoded as a command.
- R7: A control write with bit 31 set loads the status register with 0x80040000, before R8 is applied. It also returns rx_state to 0 and restarts the word index and the word count.
- R8: Every control write loads status bits 28:27 from bits 30:29 of the written value. All other status bits are left unchanged unless R7 applies.
- R9: rd_data shows the status register when rd_sel is 1 and reads zero when rd_sel is 0.
- R10: A data write in state 0 never raises tbl_we, and wr_en low never raises tbl_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | 1 | Write target: 0 command/data port, 1 control register |
| wr_data | input | 32 | Written word |
| rd_sel | input | 1 | Read select: 1 status register, 0 data port (reads zero) |
| rd_data | output | 32 | Read data, combinational |
| rx_state | output | 3 | Receive state: 0 command, 1 block, 2 luma quant, 3 luma+chroma quant, 4 scale |
| tbl_we | output | 1 | Parameter word strobe to the table memory |
| tbl_kind | output | 1 | 0 quant table, 1 scale table |
| tbl_idx | output | 6 | Word index within the table being loaded |
| tbl_data | output | 32 | Parameter word to store |

## Verification
The assertions check on every cycle that the word index steps by one between parameter words and that the last word returns the machine to the command state. They also check that a control reset clears the state and loads the status value, and that status bits 28:27 follow the control write and otherwise hold. They check that the block-data state is never entered. Only the bench's scenarios show the command decode itself: the word counts of 16 and 32, the no-op opcodes, the table kind, and a control reset that lands in the middle of a table load. The bench checks these against its own model under mixed random and directed word streams.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  typedef enum logic [2:0] {
    RX_CMD   = 3'd0,
    RX_BLOCK = 3'd1,
    RX_QLUMA = 3'd2,
    RX_QBOTH = 3'd3,
    RX_SCALE = 3'd4
  } rx_state_e;

  localparam logic [2:0]  OP_DECODE  = 3'd1;
  localparam logic [2:0]  OP_QUANT   = 3'd2;
  localparam logic [2:0]  OP_SCALE   = 3'd3;
  localparam logic [31:0] STATUS_RST = 32'h8004_0000;

  // opcode field of a command word
  function automatic logic [2:0] op_of(input logic [31:0] word);
    return word[31:29];
  endfunction

  // status value after a control write
  function automatic logic [31:0] status_after_ctl(input logic [31:0] cur,
                                                   input logic [31:0] val);
    logic [31:0] s;
    s = val[31] ? STATUS_RST : cur;
    s[28:27] = val[30:29];
    return s;
  endfunction

  function automatic logic is_param_state(input rx_state_e st);
    return (st == RX_QLUMA) || (st == RX_QBOTH) || (st == RX_SCALE);
  endfunction

endpackage

// File: rtl/mbd_cmd_decode.sv
module mbd_cmd_decode #(
  parameter int LUMA_WORDS  = 16,
  parameter int FULL_WORDS  = 32,
  parameter int SCALE_WORDS = 32,
  parameter int CNT_W       = 6
) (
  input  logic [31:0]        word,
  output mbd_pkg::rx_state_e cmd_next,
  output logic [CNT_W-1:0]   cmd_count
);
  import mbd_pkg::*;

  always_comb begin
    cmd_next  = RX_CMD;
    cmd_count = '0;
    case (op_of(word))
      OP_QUANT: begin
        if (word[0]) begin
          cmd_next  = RX_QBOTH;
          cmd_count = CNT_W'(FULL_WORDS);
        end else begin
          cmd_next  = RX_QLUMA;
          cmd_count = CNT_W'(LUMA_WORDS);
        end
      end
      OP_SCALE: begin
        cmd_next  = RX_SCALE;
        cmd_count = CNT_W'(SCALE_WORDS);
      end
      OP_DECODE: begin
        cmd_next  = RX_CMD;  // accepted, no effect in this block
        cmd_count = '0;
      end
      default: begin
        cmd_next  = RX_CMD;
        cmd_count = '0;
      end
    endcase
  end

endmodule

// File: rtl/mbd_param_ctr.sv
module mbd_param_ctr #(
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic               ctl_clr,
  input  mbd_pkg::rx_state_e cmd_next,
  input  logic [CNT_W-1:0]   cmd_count,
  output mbd_pkg::rx_state_e state,
  output logic [CNT_W-1:0]   idx,
  output logic               last_word,
  output logic               param_wr
);
  import mbd_pkg::*;

  logic [CNT_W-1:0] remaining;
  logic             in_param;

  assign in_param  = is_param_state(state);
  assign param_wr  = data_wr && in_param;
  assign last_word = (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_CMD;
      remaining <= '0;
      idx       <= '0;
    end else if (ctl_clr) begin
      state     <= RX_CMD;
      remaining <= '0;
      idx       <= '0;
    end else if (data_wr) begin
      if (state == RX_CMD) begin
        state     <= cmd_next;
        remaining <= cmd_count;
        idx       <= '0;
      end else if (in_param) begin
        remaining <= remaining - CNT_W'(1);
        idx       <= idx + CNT_W'(1);
        if (last_word) state <= RX_CMD;
      end else begin
        state <= RX_CMD;
      end
    end
  end

endmodule

// File: rtl/mbd_status_reg.sv
module mbd_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_data,
  output logic [31:0] status
);
  import mbd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status <= STATUS_RST;
    else if (ctl_wr) status <= status_after_ctl(status, ctl_data);
  end

endmodule

// File: rtl/mbd_cmd_front.sv
module mbd_cmd_front #(
  parameter int LUMA_WORDS  = 16,
  parameter int FULL_WORDS  = 32,
  parameter int SCALE_WORDS = 32,
  localparam int MAX_WORDS  = (FULL_WORDS > SCALE_WORDS) ? FULL_WORDS : SCALE_WORDS,
  localparam int CNT_W      = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  output logic [2:0]       rx_state,
  output logic             tbl_we,
  output logic             tbl_kind,
  output logic [CNT_W-1:0] tbl_idx,
  output logic [31:0]      tbl_data
);
  import mbd_pkg::*;

  logic             data_wr, ctl_wr, ctl_clr;
  logic             param_wr, last_word;
  rx_state_e        cmd_next, state_q;
  logic [CNT_W-1:0] cmd_count;
  logic [31:0]      status_q;

  assign data_wr = wr_en && !wr_sel;
  assign ctl_wr  = wr_en && wr_sel;
  assign ctl_clr = ctl_wr && wr_data[31];

  mbd_cmd_decode #(
    .LUMA_WORDS (LUMA_WORDS),
    .FULL_WORDS (FULL_WORDS),
    .SCALE_WORDS(SCALE_WORDS),
    .CNT_W      (CNT_W)
  ) u_dec (
    .word     (wr_data),
    .cmd_next (cmd_next),
    .cmd_count(cmd_count)
  );

  mbd_param_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .ctl_clr  (ctl_clr),
    .cmd_next (cmd_next),
    .cmd_count(cmd_count),
    .state    (state_q),
    .idx      (tbl_idx),
    .last_word(last_word),
    .param_wr (param_wr)
  );

  mbd_status_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .ctl_data(wr_data),
    .status  (status_q)
  );

  assign rx_state = state_q;
  assign tbl_we   = param_wr;
  assign tbl_kind = (state_q == RX_SCALE);
  assign tbl_data = wr_data;
  assign rd_data  = rd_sel ? status_q : 32'h0;

endmodule

// File: rtl/mbd_cmd_front_chk.sv
module mbd_cmd_front_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [31:0]      wr_data,
  input logic             param_wr,
  input logic             last_word,
  input logic [2:0]       state,
  input logic [CNT_W-1:0] idx,
  input logic [31:0]      status
);

  p_no_block_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state != 3'd1);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (param_wr && !last_word && !ctl_wr) |=> (idx == $past(idx) + CNT_W'(1)));

  p_back_to_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (param_wr && last_word) |=> (state == 3'd0));

  p_ctl_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[31]) |=>
      (state == 3'd0 && idx == '0 &&
       status == (32'h8004_0000 | {3'b000, $past(wr_data[30:29]), 27'h0})));

  p_status_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (status[28:27] == $past(wr_data[30:29])));

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(status));

endmodule

bind mbd_cmd_front mbd_cmd_front_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_wr   (ctl_wr),
  .wr_data  (wr_data),
  .param_wr (param_wr),
  .last_word(last_word),
  .state    (rx_state),
  .idx      (tbl_idx),
  .status   (status_q)
);

// File: tb/mbd_cmd_front_tb.sv
`timescale 1ns/1ps
module mbd_cmd_front_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [2:0]  rx_state;
  logic        tbl_we, tbl_kind;
  logic [5:0]  tbl_idx;
  logic [31:0] tbl_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  int          m_st = 0, m_rem = 0, m_idx = 0;
  logic [31:0] m_status = 32'h8004_0000;

  always #5 clk = ~clk;

  mbd_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .rx_state(rx_state), .tbl_we(tbl_we), .tbl_kind(tbl_kind),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit param_st(input int st);
    return st == 2 || st == 3 || st == 4;
  endfunction

  function automatic logic [31:0] ctl_result(input logic [31:0] cur, input logic [31:0] v);
    logic [31:0] r;
    r = v[31] ? 32'h8004_0000 : cur;
    r = (r & ~32'h1800_0000) | ((v >> 2) & 32'h1800_0000);
    return r;
  endfunction

  task automatic model_step(input bit sel, input logic [31:0] d);
    if (sel) begin
      if (d[31]) begin m_st = 0; m_rem = 0; m_idx = 0; end
      m_status = ctl_result(m_status, d);
    end else if (m_st == 0) begin
      if (d[31:29] == 3'd2) begin
        m_st = d[0] ? 3 : 2; m_rem = d[0] ? 32 : 16; m_idx = 0;
      end else if (d[31:29] == 3'd3) begin
        m_st = 4; m_rem = 32; m_idx = 0;
      end
    end else begin
      m_rem--; m_idx++;
      if (m_rem == 0) m_st = 0;
    end
  endtask

  // one write; checks table strobe before the edge, state/status after
  task automatic put(input bit sel, input logic [31:0] d, input string req_st);
    bit exp_we;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    #2;
    exp_we = !sel && param_st(m_st);
    chk(tbl_we == exp_we, exp_we ? "R5" : "R10", tbl_we, exp_we);
    if (exp_we) begin
      chk(tbl_idx == 6'(m_idx), "R5 idx", tbl_idx, m_idx);
      chk(tbl_kind == (m_st == 4), "R5 kind", tbl_kind, m_st == 4);
      chk(tbl_data == d, "R5 data", tbl_data, d);
    end
    model_step(sel, d);
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    chk(rx_state == 3'(m_st), req_st, rx_state, m_st);
    rd_sel = 1'b1; #1;
    chk(rd_data == m_status, "R8/R9 status", rd_data, m_status);
  endtask

  task automatic load_table(input logic [31:0] cmd, input int words, input int exp_st, input string req);
    put(1'b0, cmd, req);
    chk(rx_state == 3'(exp_st), req, rx_state, exp_st);
    for (int i = 0; i < words; i++)
      put(1'b0, $urandom(), (i == words - 1) ? "R6" : req);
    chk(rx_state == 3'd0, "R6", rx_state, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rx_state == 3'd0, "R1 state", rx_state, 0);
    rd_sel = 1'b1; #1;
    chk(rd_data == 32'h8004_0000, "R1 status", rd_data, 32'h8004_0000);
    rd_sel = 1'b0; #1;
    chk(rd_data == 32'h0, "R9 data port read", rd_data, 0);

    // R2 / R3 directed loads
    load_table(32'h4000_0000, 16, 2, "R2");
    load_table(32'h4000_0001, 32, 3, "R2");
    load_table(32'h6000_0000, 32, 4, "R3");

    // R4: every no-op opcode, including decode
    for (int op = 0; op < 8; op++)
      if (op != 2 && op != 3) put(1'b0, {3'(op), 29'h0ABC_DEF1}, "R4");

    // R8 then R7
    put(1'b1, 32'h6000_0000, "R8");
    put(1'b1, 32'h2000_0000, "R8");
    put(1'b1, 32'h0000_0000, "R8");
    put(1'b0, 32'h4000_0001, "R2");
    for (int i = 0; i < 5; i++) put(1'b0, $urandom(), "R5");
    put(1'b1, 32'hC000_0000, "R7");
    chk(rx_state == 3'd0, "R7 mid-load reset", rx_state, 0);
    put(1'b0, 32'h6000_0000, "R3");
    put(1'b0, 32'h1111_1111, "R5");
    chk(tbl_idx == 6'd1, "R7 index restarted", tbl_idx, 1);
    put(1'b1, 32'h8000_0000, "R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      int r;
      r = int'($urandom_range(0, 99));
      d = $urandom();
      if (r < 6) put(1'b1, d, "R7/R8");
      else if (m_st == 0 && r < 40) put(1'b0, {2'b01, d[29:0]}, "R2/R3");
      else put(1'b0, d, "R4/R5/R6");
      if (r == 50) begin
        rd_sel = 1'b0; #1;
        chk(rd_data == 32'h0, "R9", rd_data, 0);
        rd_sel = 1'b1;
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule